// File: doc/BRIEF.md
# Single-Precision to Signed Integer Truncation Unit

This unit takes one IEEE 754 single-precision word at a time and turns it into a signed 32-bit two's-complement integer. It always rounds toward zero and ignores any rounding mode set elsewhere in the system. The integer comes out together with two exception flags, invalid and inexact, and a summary bit that is set when either flag is set. All outputs are registered and appear one clock after an input strobe.

All special operands are resolved inside the unit. Any NaN gives the integer 0. Infinities and magnitudes beyond the signed 32-bit range saturate. Zeros and subnormals give 0. The flags follow one fixed rule: an invalid outcome always suppresses inexact, even when fraction bits were dropped. A consumer such as an execution stage can therefore merge the flags into its own status without any extra masking.

Top module: `f2i_trunc`

## Requirements
- R1: For a finite normal operand whose truncated magnitude fits in signed 32 bits, the integer result is the operand truncated toward zero. The operand layout is sign in bit 31, biased exponent (bias 127) in bits 30:23 and fraction in bits 22:0.
- R2: An operand with exponent field 255 and a nonzero fraction (a NaN, quiet or signaling) gives integer 0 with invalid set.
- R3: Whenever invalid is set, inexact is clear, even if nonzero fraction bits were discarded.
- R4: The summary bit is 1 exactly when invalid or inexact is set, and is 0 when neither is set.
- R5: Infinities, and finite operands whose truncated value lies outside [-2^31, 2^31-1], give 0x7FFFFFFF for a positive sign or 0x80000000 for a negative sign, with invalid set.
- R6: The operand 0xCF000000 (exactly -2^31) gives 0x80000000 with no flag set.
- R7: A valid conversion that discards nonzero fraction bits sets inexact; an exact one leaves it clear.
- R8: Zero and subnormal operands (exponent field 0) of either sign give 0. A subnormal operand sets inexact; a zero sets no flag.
- R9: Results and flags appear on the clock edge after the one that samples in_valid high, with out_valid high for that one cycle. out_valid is low after a cycle with in_valid low. A synchronous active-high reset clears out_valid, the result and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_int | output | 32 | Signed integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_status | output | 1 | Summary bit: any flag set |

## Verification
Properties watch every cycle for several port-level rules. They check the one-cycle strobe timing and the reset clearing. They check that invalid and inexact are never set together, that the summary bit matches the flags, that a NaN at the input yields 0 with invalid, that zeros give 0 with no flag, and that any nonzero result with invalid set is one of the two saturation codes. Only the bench scenarios can show the exact truncated value for each operand. The same holds for the boundary between -2^31 and saturation, the inexact decision on dropped fraction bits, and the subnormal handling. The bench computes all of these from a real-number model of each operand.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    parameter int EXP_W = 8;
    parameter int MAN_W = 23;
    parameter int INT_W = 32;
    parameter int BIAS  = (1 << (EXP_W - 1)) - 1;

    localparam int FP_W   = 1 + EXP_W + MAN_W;
    localparam int WIDE_W = MAN_W + INT_W;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBN,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } op_class_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic invalid;
        logic inexact;
    } cvt_flags_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        cvt_flags_t       flags;
    } cvt_res_t;

    function automatic logic [INT_W-1:0] sat_code(input logic neg);
        return neg ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [FP_W-1:0] word,
    output fp_word_t        fields,
    output op_class_e       cls
);
    always_comb begin
        fields = fp_word_t'(word);
        if (&fields.expo)
            cls = (|fields.frac) ? CLS_NAN : CLS_INF;
        else if (fields.expo == '0)
            cls = (|fields.frac) ? CLS_SUBN : CLS_ZERO;
        else
            cls = CLS_NORM;
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  logic [EXP_W-1:0] expo,
    input  logic [MAN_W-1:0] frac,
    output logic [INT_W-1:0] mag,
    output logic             lost,
    output logic             too_big,
    output logic             at_min
);
    localparam logic [EXP_W:0] BIAS_E = (EXP_W+1)'(BIAS);
    localparam logic [EXP_W:0] LIM_E  = (EXP_W+1)'(BIAS + INT_W - 1);

    logic [EXP_W:0]  ext_exp;
    logic [EXP_W:0]  sh;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        ext_exp = {1'b0, expo};
        sh      = ext_exp - BIAS_E;
        wide    = '0;
        mag     = '0;
        lost    = 1'b0;
        too_big = 1'b0;
        at_min  = 1'b0;
        if (ext_exp < BIAS_E) begin
            lost = 1'b1;
        end else if (ext_exp >= LIM_E) begin
            too_big = 1'b1;
            at_min  = (ext_exp == LIM_E) && (frac == '0);
        end else begin
            wide = WIDE_W'({1'b1, frac}) << sh;
            mag  = wide[MAN_W +: INT_W];
            lost = |wide[MAN_W-1:0];
        end
    end
endmodule

// File: rtl/f2i_resolve.sv
module f2i_resolve
    import f2i_pkg::*;
(
    input  op_class_e        cls,
    input  logic             sign,
    input  logic [INT_W-1:0] mag,
    input  logic             lost,
    input  logic             too_big,
    input  logic             at_min,
    output cvt_res_t         res
);
    logic raw_inexact;

    always_comb begin
        res.value         = '0;
        res.flags.invalid = 1'b0;
        raw_inexact       = 1'b0;
        unique case (cls)
            CLS_NAN:  res.flags.invalid = 1'b1;
            CLS_INF: begin
                res.value         = sat_code(sign);
                res.flags.invalid = 1'b1;
            end
            CLS_SUBN: raw_inexact = 1'b1;
            CLS_NORM: begin
                if (too_big) begin
                    res.value         = sat_code(sign);
                    res.flags.invalid = !(sign && at_min);
                end else begin
                    res.value   = sign ? ('0 - mag) : mag;
                    raw_inexact = lost;
                end
            end
            default: ;
        endcase
        // invalid outcome masks inexact (R3)
        res.flags.inexact = raw_inexact && !res.flags.invalid;
    end
endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  in_data,
    output logic             out_valid,
    output logic [INT_W-1:0] out_int,
    output logic             out_invalid,
    output logic             out_inexact,
    output logic             out_status
);
    fp_word_t         fields;
    op_class_e        cls;
    logic [INT_W-1:0] mag;
    logic             lost, too_big, at_min;
    cvt_res_t         res;
    cvt_res_t         res_q;
    logic             vld_q;

    f2i_unpack u_unpack (
        .word   (in_data),
        .fields (fields),
        .cls    (cls)
    );

    f2i_align u_align (
        .expo    (fields.expo),
        .frac    (fields.frac),
        .mag     (mag),
        .lost    (lost),
        .too_big (too_big),
        .at_min  (at_min)
    );

    f2i_resolve u_resolve (
        .cls     (cls),
        .sign    (fields.sign),
        .mag     (mag),
        .lost    (lost),
        .too_big (too_big),
        .at_min  (at_min),
        .res     (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                res_q <= res;
        end
    end

    assign out_valid   = vld_q;
    assign out_int     = res_q.value;
    assign out_invalid = res_q.flags.invalid;
    assign out_inexact = res_q.flags.inexact;
    assign out_status  = res_q.flags.invalid | res_q.flags.inexact;

    localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MIN_NEG = {1'b1, {(INT_W-1){1'b0}}};

    p_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_int == '0 && !out_status));
    p_flag_excl_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_invalid && out_inexact));
    p_summary_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_status == (out_invalid || out_inexact)));
    p_nan_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&in_data[FP_W-2 -: EXP_W]) && (|in_data[MAN_W-1:0]))
        |=> (out_int == '0 && out_invalid));
    p_sat_code_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_invalid && out_int != '0)
        |-> (out_int == MAX_POS || out_int == MIN_NEG));
    p_zero_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[FP_W-2:0] == '0)
        |=> (out_int == '0 && !out_status));
endmodule

// File: tb/f2i_trunc_tb.sv
module f2i_trunc_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_data;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_invalid, out_inexact, out_status;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    f2i_trunc u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
        .out_inexact(out_inexact), .out_status(out_status)
    );

    function automatic real pow2(input int n);
        real p = 1.0;
        if (n >= 0) for (int i = 0; i < n; i++) p = p * 2.0;
        else        for (int i = 0; i < -n; i++) p = p / 2.0;
        return p;
    endfunction

    // reference model built on real arithmetic
    task automatic model(input logic [31:0] w, output logic [31:0] v,
                         output logic inv, output logic inx, output string tag);
        logic s = w[31];
        int   e = int'(w[30:23]);
        int   m = int'(w[22:0]);
        real  r;
        int   t;
        v = 32'd0; inv = 1'b0; inx = 1'b0;
        if (e == 255 && m != 0) begin
            inv = 1'b1; tag = "R2";
        end else if (e == 255) begin
            v = s ? 32'h8000_0000 : 32'h7FFF_FFFF; inv = 1'b1; tag = "R5";
        end else if (e == 0) begin
            inx = (m != 0); tag = "R8";
        end else begin
            r = (8388608.0 + real'(m)) * pow2(e - 150);
            if (s) r = -r;
            if (r >= 2147483648.0 || r < -2147483648.0) begin
                v = s ? 32'h8000_0000 : 32'h7FFF_FFFF; inv = 1'b1; tag = "R5";
            end else begin
                t   = $rtoi(r);
                v   = t;
                inx = ($itor(t) != r);
                tag = (w == 32'hCF00_0000) ? "R6" : (inx ? "R7" : "R1");
            end
        end
    endtask

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp, input logic [31:0] op);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%h actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    task automatic convert(input logic [31:0] w);
        logic [31:0] ev;
        logic        ei, ex;
        string       tg;
        model(w, ev, ei, ex, tg);
        @(negedge clk);
        in_data  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", {63'd0, out_valid}, 64'd1, w);
        check(tg, {30'd0, out_int, ei, ex}, {30'd0, ev, ei, ex}, w);
        check(tg, {30'd0, out_int, out_invalid, out_inexact},
              {30'd0, ev, ei, ex}, w);
        if (ei) check("R3", {63'd0, out_inexact}, 64'd0, w);
        check("R4", {63'd0, out_status}, {63'd0, ei | ex}, w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_data = 32'h0;
        repeat (3) @(negedge clk);
        check("R9", {30'd0, out_valid, out_int, out_status}, 64'd0, 32'h0);
        rst = 1'b0;

        convert(32'h3FC0_0000); // 1.5 -> 1, inexact (R7)
        convert(32'hBFC0_0000); // -1.5 -> -1 (R1, R7)
        convert(32'h3F00_0000); // 0.5
        convert(32'h4B7F_FFFF); // 16777215 exact
        convert(32'h4EFF_FFFF); // largest in-range float
        convert(32'hCEFF_FFFF);
        convert(32'h7FC0_0000); // quiet NaN (R2)
        convert(32'h7F80_0001); // signaling NaN (R2)
        convert(32'hFFC0_0001);
        convert(32'h7F80_0000); // +inf (R5)
        convert(32'hFF80_0000); // -inf (R5)
        convert(32'h4F00_0000); // 2^31 saturates (R5)
        convert(32'hCF00_0000); // -2^31 exact (R6)
        convert(32'hCF00_0001); // just below -2^31 (R5)
        convert(32'h0000_0000); // zeros (R8)
        convert(32'h8000_0000);
        convert(32'h0000_0001); // subnormals (R8)
        convert(32'h807F_FFFF);

        // idle cycle: no strobe (R9)
        @(negedge clk);
        check("R9", {63'd0, out_valid}, 64'd0, 32'h0);

        for (int i = 0; i < 1500; i++) convert($urandom);
        for (int i = 0; i < 1500; i++) begin
            w = $urandom;
            w[30:23] = 8'($urandom_range(165, 110));
            convert(w);
        end

        // reset with a strobe pending clears outputs (R9)
        @(negedge clk);
        in_data = 32'h3FC0_0000; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        check("R9", {30'd0, out_valid, out_int, out_status}, 64'd0, 32'h3FC0_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule